// File: doc/BRIEF.md
# Weighted Input Summation with Delay

This block forms the input stage of one model neuron. It receives a packed vector of signed presynaptic voltages, scales each by a fixed signed weight, and adds the products into one wide sum. The sum is clipped to the output width and captured on a tick strobe. It then passes through a single delay chain before it reaches the neuron.

Only one delay chain exists per summation node. It sits after the adder, so the register count depends on the output width and the delay length. It does not grow with the number of incoming connections. Weights, the number of inputs, the word widths and the delay length are all elaboration-time parameters. A negative weight models an inhibitory connection and a positive weight models an excitatory one.

Top module: `weighted_delay_sum`

## Requirements
- R1: On a tick, the block captures the sum over all k of signed(vIn[k*IN_W +: IN_W]) times signed(WEIGHTS[k*W_W +: W_W]). With the default parameters (4 inputs, 12-bit inputs, 8-bit weights) the weights are 3, -2, 5 and -7 for inputs 0 to 3.
- R2: A sum above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1. A sum below -2^(OUT_W-1) is output as -2^(OUT_W-1). With OUT_W=16 these limits are 32767 and -32768.
- R3: The block captures a sum only on a clock edge where tick is high. Input changes on other cycles have no effect on the output.
- R4: A sum captured on tick number t appears on iOut immediately after tick number t+DELAY. The default DELAY is 6.
- R5: iOut changes only on a clock edge where tick is high. On every other cycle it holds its value.
- R6: Reset (rstN low) clears the captured sum and every delay stage to zero. iOut reads 0 during reset and after each of the first DELAY ticks that follow it, whatever the inputs are.
- R7: A configuration with one input and DELAY=0 is supported. Its iOut shows the clipped product of that input immediately after the tick that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Simulation step strobe; captures a sum and advances the delay chain |
| vIn | input | NUM_IN*IN_W | Packed signed presynaptic voltages; input k is at bits [k*IN_W +: IN_W] |
| iOut | output | OUT_W | Delayed, clipped weighted sum |

## Verification
On every tick, two things happen on the same edge: the adder's result is captured, and the delay chain shifts the previous capture one stage onward. Back-to-back ticks with different input vectors make a wrong ordering visible as a duplicated or skipped value. Saturating input extremes are placed into such tick runs. The bench keeps a history of the expected clipped sum for every tick and compares iOut against the entry DELAY ticks back. Between ticks it changes the inputs freely and expects iOut to stay unchanged.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

  typedef struct packed {
    logic loadSum;
    logic shiftLine;
  } wsd_strobes_t;

endpackage

// File: rtl/wsd_ctrl.sv
module wsd_ctrl
  import wsd_pkg::*;
(
  input  logic         tick,
  output wsd_strobes_t strb
);

  always_comb begin
    strb.loadSum   = tick;
    strb.shiftLine = tick;
  end

endmodule

// File: rtl/wsd_datapath.sv
module wsd_datapath
  import wsd_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int IN_W   = 12,
  parameter int W_W    = 8,
  parameter int OUT_W  = 16,
  parameter int DELAY  = 6,
  parameter logic [NUM_IN*W_W-1:0] WEIGHTS = {8'hF9, 8'h05, 8'hFE, 8'h03}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wsd_strobes_t             strb,
  input  logic [NUM_IN*IN_W-1:0]   vIn,
  output logic signed [OUT_W-1:0]  iOut
);

  localparam int SUM_W = IN_W + W_W + $clog2(NUM_IN);

  logic signed [SUM_W-1:0] prod [NUM_IN];
  logic signed [SUM_W-1:0] wideSum;
  logic signed [OUT_W-1:0] satSum;
  logic signed [OUT_W-1:0] sumReg;

  // One multiplier per input, each with its constant weight
  for (genvar k = 0; k < NUM_IN; k++) begin : g_prod
    logic signed [SUM_W-1:0] xExt;
    logic signed [SUM_W-1:0] wExt;
    assign xExt    = SUM_W'($signed(vIn[k*IN_W +: IN_W]));
    assign wExt    = SUM_W'($signed(WEIGHTS[k*W_W +: W_W]));
    assign prod[k] = xExt * wExt;
  end

  always_comb begin
    wideSum = '0;
    for (int k = 0; k < NUM_IN; k++) wideSum = wideSum + prod[k];
  end

  // Clip the wide sum to the output width
  if (SUM_W > OUT_W) begin : g_sat
    localparam logic signed [SUM_W-1:0] SAT_HI = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SAT_LO = {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [OUT_W-1:0] OUT_HI = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] OUT_LO = {1'b1, {(OUT_W-1){1'b0}}};

    always_comb begin
      if (wideSum > SAT_HI)      satSum = OUT_HI;
      else if (wideSum < SAT_LO) satSum = OUT_LO;
      else                       satSum = OUT_W'(wideSum);
    end

    assert_sat_high_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.loadSum && wideSum > SAT_HI) |=> sumReg == OUT_HI);
    assert_sat_low_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.loadSum && wideSum < SAT_LO) |=> sumReg == OUT_LO);
    assert_capture_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
      (strb.loadSum && wideSum <= SAT_HI && wideSum >= SAT_LO)
        |=> sumReg == $past(OUT_W'(wideSum)));
  end else begin : g_nosat
    assign satSum = OUT_W'(wideSum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sumReg <= '0;
    else if (strb.loadSum) sumReg <= satSum;
  end

  assert_sum_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadSum |=> $stable(sumReg));

  // Single delay chain after the adder
  if (DELAY == 0) begin : g_nodelay
    assign iOut = sumReg;
  end else begin : g_delay
    logic signed [OUT_W-1:0] stage [DELAY];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DELAY; i++) stage[i] <= '0;
      end else if (strb.shiftLine) begin
        stage[0] <= sumReg;
        for (int i = 1; i < DELAY; i++) stage[i] <= stage[i-1];
      end
    end

    assign iOut = stage[DELAY-1];

    assert_line_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
      strb.shiftLine |=> stage[0] == $past(sumReg));
  end

endmodule

// File: rtl/weighted_delay_sum.sv
module weighted_delay_sum
  import wsd_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int IN_W   = 12,
  parameter int W_W    = 8,
  parameter int OUT_W  = 16,
  parameter int DELAY  = 6,
  parameter logic [NUM_IN*W_W-1:0] WEIGHTS = {8'hF9, 8'h05, 8'hFE, 8'h03}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic [NUM_IN*IN_W-1:0]  vIn,
  output logic [OUT_W-1:0]        iOut
);

  wsd_strobes_t strb;
  logic signed [OUT_W-1:0] outWord;

  wsd_ctrl u_ctrl (
    .tick (tick),
    .strb (strb)
  );

  wsd_datapath #(
    .NUM_IN (NUM_IN),
    .IN_W   (IN_W),
    .W_W    (W_W),
    .OUT_W  (OUT_W),
    .DELAY  (DELAY),
    .WEIGHTS(WEIGHTS)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .vIn  (vIn),
    .iOut (outWord)
  );

  assign iOut = outWord;

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(iOut));

endmodule

// File: tb/weighted_delay_sum_tb.sv
module weighted_delay_sum_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int IW    = 12;
  localparam int OW    = 16;
  localparam int DLY   = 6;
  localparam int NTICK = 260;

  logic clk = 0;
  logic rstN = 0;
  logic tick = 0;
  logic [N*IW-1:0] vIn = '0;
  logic [OW-1:0]   iOut;
  logic [IW-1:0]   vShort = '0;
  logic [OW-1:0]   iShort;

  int wTab [N] = '{3, -2, 5, -7};
  int hist [NTICK+8];
  int nTick = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  weighted_delay_sum #(.DELAY(DLY)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .vIn(vIn), .iOut(iOut)
  );

  weighted_delay_sum #(.NUM_IN(1), .DELAY(0), .WEIGHTS(8'hFB)) u_dutShort (
    .clk(clk), .rstN(rstN), .tick(tick), .vIn(vShort), .iOut(iShort)
  );

  function automatic int clip(int a);
    if (a > 32767) return 32767;
    if (a < -32768) return -32768;
    return a;
  endfunction

  function automatic int expSum(logic [N*IW-1:0] v);
    int acc = 0;
    for (int k = 0; k < N; k++) acc += int'($signed(v[k*IW +: IW])) * wTab[k];
    return clip(acc);
  endfunction

  function automatic int expected();
    if (nTick - 1 - DLY < 0) return 0;
    return hist[nTick - 1 - DLY];
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", tag, act, exp, nTick);
    end
  endtask

  task automatic randomize_inputs();
    for (int k = 0; k < N; k++) vIn[k*IW +: IW] = IW'($urandom);
    vShort = IW'($urandom);
  endtask

  task automatic do_tick();
    int expShort;
    @(negedge clk);
    tick = 1;
    hist[nTick] = expSum(vIn);
    expShort = clip(int'($signed(vShort)) * -5);
    @(negedge clk);
    tick = 0;
    nTick++;
    if (nTick - 1 < DLY) check("R6", int'($signed(iOut)), 0);
    else if (expected() == 32767 || expected() == -32768)
      check("R2", int'($signed(iOut)), expected());
    else check("R4/R1", int'($signed(iOut)), expected());
    check("R7", int'($signed(iShort)), expShort);
  endtask

  task automatic idle(int cycles);
    for (int c = 0; c < cycles; c++) begin
      randomize_inputs();
      @(negedge clk);
      check("R3/R5", int'($signed(iOut)), expected());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4021);
    randomize_inputs();
    tick = 1;
    repeat (3) @(negedge clk);
    check("R6", int'($signed(iOut)), 0);
    check("R6", int'($signed(iShort)), 0);
    tick = 0;
    rstN = 1;
    @(negedge clk);
    check("R6", int'($signed(iOut)), 0);

    for (int t = 0; t < 220; t++) begin
      randomize_inputs();
      if (t % 37 == 5) begin
        vIn = {12'h800, 12'h7FF, 12'h800, 12'h7FF};
      end else if (t % 37 == 6) begin
        vIn = {12'h7FF, 12'h800, 12'h7FF, 12'h800};
      end else if (t % 37 == 7) begin
        vIn = '0;
        vShort = 12'h800;
      end
      do_tick();
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end

    check("R2", expSum({12'h800, 12'h7FF, 12'h800, 12'h7FF}), 32767);
    for (int t = 0; t < DLY + 2; t++) begin
      randomize_inputs();
      do_tick();
    end

    rstN = 0;
    @(negedge clk);
    check("R6", int'($signed(iOut)), 0);
    rstN = 1;
    nTick = 0;
    for (int t = 0; t < DLY + 3; t++) begin
      randomize_inputs();
      do_tick();
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule